// File: doc/BRIEF.md
# Reversible ripple-carry adder-subtractor

This block is a clocked engine that reproduces, on ordinary flip-flops, the behaviour of an in-place adder built only from self-inverse reversible gates. It keeps three registers: an operand `a` of N bits, a result register `b` of N+1 bits, and a carry scratch register of N-1 bits. A start pulse loads `a` and `b` and clears the scratch. The engine then executes one gate step per clock from a fixed program. Each step is a controlled-NOT or a Toffoli.

The program has two phases. In the first phase the carries are generated from bit 0 upwards, and the final carry lands in the top bit of `b`. In the second phase the carry steps are unwound from the top down. During that unwinding, each sum bit `a_i XOR b_i XOR c_i` is written over `b_i`. At the end the scratch register is back at zero. Every step is its own inverse. For that reason, subtract mode simply plays the same program from its last step to its first. The result replaces `b` with `b - a`, or with the value wrapped modulo 2^(N+1) when that difference is negative. The top result bit therefore doubles as a "b is below a" flag.

A caller drives `start` with `sub_mode`, `a_in` and `b_in` while the engine is idle. It then waits for the one-cycle `done` pulse and reads `sum_out` and `sign_out`.

Top module: `rev_adder_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and `a_out`, `sum_out` and `scratch_out` are all zero.
- R2: Add mode (`sub_mode`=0) with `b_in[N]`=0 leaves `sum_out` equal to the (N+1)-bit sum `a_in + b_in`.
- R3: Subtract mode (`sub_mode`=1) with `b_in[N]`=0 leaves `sum_out` equal to `(b_in - a_in) mod 2^(N+1)`. This is the plain difference when `b_in >= a_in`, and `2^(N+1) - (a_in - b_in)` otherwise.
- R4: `sign_out` equals bit N of `sum_out`. After a subtraction with `b_in[N]`=0 it is 1 exactly when `b_in < a_in`.
- R5: The top input bit is carried through the gate program. In add mode, `sum_out[N-1:0] = (a_in + b_in[N-1:0]) mod 2^N` and `sum_out[N]` = carry-out XOR `b_in[N]`. Subtract mode is the exact inverse: subtracting `a` from an add result restores the original `b_in`.
- R6: The scratch register is zero when a run is loaded and again whenever `done` is 1.
- R7: The first step executes on the clock edge after the one that captures `start`. The program is 8N-2 steps long. `done` is a one-cycle pulse that appears in the cycle after the last step. `busy` is high from the capture until that last step.
- R8: While `busy` is 1, `start`, `sub_mode`, `a_in` and `b_in` are ignored. A run's result depends only on the values captured with `start`.
- R9: `a_out` keeps the captured `a_in` through the whole run and after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; taken only while idle |
| sub_mode | input | 1 | 0 = add (program forwards), 1 = subtract (program backwards) |
| a_in | input | N | Operand a |
| b_in | input | N+1 | Initial contents of the result register |
| busy | output | 1 | A gate program is running |
| done | output | 1 | One-cycle pulse after the last step |
| a_out | output | N | Current contents of the a register |
| sum_out | output | N+1 | Current contents of the result register |
| scratch_out | output | N-1 | Current contents of the carry scratch register |
| sign_out | output | 1 | Top bit of the result register (overflow / comparison flag) |

## Verification
The assertions assume three things. Reset is applied before the first run. A run ends only through `done`. Nothing outside the engine writes its registers, so `a_out` can only change on a capture. They make no assumption about operand values. The stimulus covers every `a_in`/`b_in` pair in both modes, including `b_in` values with the top bit set. It holds `start` and scrambled operands high through random runs so that the idle-only capture rule is exercised, and it releases `start` before the final step so that no second run begins on the `done` cycle.

// File: rtl/rev_adder_engine.sv
module rev_adder_engine #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sub_mode,
  input  logic [N-1:0] a_in,
  input  logic [N:0]   b_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] a_out,
  output logic [N:0]   sum_out,
  output logic [N-2:0] scratch_out,
  output logic         sign_out
);
  localparam int W     = 3 * N;
  localparam int ZERO  = W;
  localparam int ONE   = W + 1;
  localparam int IW    = $clog2(W + 2);
  localparam int STEPS = 8 * N - 2;
  localparam int KW    = $clog2(STEPS);
  localparam logic [KW-1:0] LAST = KW'(STEPS - 1);

  logic [W-1:0]  st, st_next;
  logic [KW-1:0] k;
  logic          rev;
  logic [IW-1:0] g_c1, g_c2, g_t;
  logic [W+1:0]  ext;
  logic          flip;

  function automatic int ia(int i);
    return i;
  endfunction
  function automatic int ib(int i);
    return N + i;
  endfunction
  function automatic int ic(int i);
    if (i == 0) return ZERO;
    if (i == N) return 2 * N;
    return 2 * N + i;
  endfunction

  always_comb begin
    int kk, i, s;
    kk   = int'(k);
    g_c1 = IW'(ONE);
    g_c2 = IW'(ONE);
    g_t  = '0;
    if (kk < 3 * N) begin
      i = kk / 3;
      s = kk % 3;
      case (s)
        0:       begin g_c1 = IW'(ia(i)); g_c2 = IW'(ib(i)); g_t = IW'(ic(i + 1)); end
        1:       begin g_c1 = IW'(ia(i)); g_t = IW'(ib(i)); end
        default: begin g_c1 = IW'(ic(i)); g_c2 = IW'(ib(i)); g_t = IW'(ic(i + 1)); end
      endcase
    end else if (kk < 3 * N + 2) begin
      g_c1 = IW'(ia(N - 1));
      g_t  = IW'(ib(N - 1));
    end else if (kk == 3 * N + 2) begin
      g_c1 = IW'(ic(N - 1));
      g_t  = IW'(ib(N - 1));
    end else begin
      i = N - 2 - (kk - 3 * N - 3) / 5;
      s = (kk - 3 * N - 3) % 5;
      case (s)
        0:       begin g_c1 = IW'(ic(i)); g_c2 = IW'(ib(i)); g_t = IW'(ic(i + 1)); end
        1:       begin g_c1 = IW'(ia(i)); g_t = IW'(ib(i)); end
        2:       begin g_c1 = IW'(ia(i)); g_c2 = IW'(ib(i)); g_t = IW'(ic(i + 1)); end
        3:       begin g_c1 = IW'(ia(i)); g_t = IW'(ib(i)); end
        default: begin g_c1 = IW'(ic(i)); g_t = IW'(ib(i)); end
      endcase
    end
  end

  assign ext     = {1'b1, 1'b0, st};
  assign flip    = ext[g_c1] & ext[g_c2];
  assign st_next = st ^ ({{(W-1){1'b0}}, flip} << g_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      k    <= '0;
      rev  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st   <= {{(N-1){1'b0}}, b_in, a_in};
          rev  <= sub_mode;
          k    <= sub_mode ? LAST : '0;
          busy <= 1'b1;
        end
      end else begin
        st <= st_next;
        if (rev ? (k == '0) : (k == LAST)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          k <= rev ? k - 1'b1 : k + 1'b1;
        end
      end
    end
  end

  assign a_out       = st[N-1:0];
  assign sum_out     = st[2*N:N];
  assign scratch_out = st[W-1:2*N+1];
  assign sign_out    = st[2*N];
endmodule

// File: rtl/rev_adder_engine_chk.sv
module rev_adder_engine_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] a_out,
  input logic [N-2:0] scratch_out
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_end_via_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  assert_scratch_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scratch_out == '0));
  assert_scratch_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (scratch_out == '0));
  assert_a_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(a_out));
  assert_a_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(a_out));
endmodule

bind rev_adder_engine rev_adder_engine_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .a_out(a_out), .scratch_out(scratch_out)
);

// File: tb/rev_adder_engine_bench.sv
`timescale 1ns/1ps
module rev_adder_engine_bench;
  localparam int N = 4;
  localparam int T = 8 * N - 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sub_mode = 1'b0;
  logic [N-1:0] a_in = '0;
  logic [N:0]   b_in = '0;
  logic         busy, done, sign_out;
  logic [N-1:0] a_out;
  logic [N:0]   sum_out;
  logic [N-2:0] scratch_out;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rev_adder_engine #(.N(N)) u_rev_adder_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .sub_mode(sub_mode),
    .a_in(a_in), .b_in(b_in), .busy(busy), .done(done), .a_out(a_out),
    .sum_out(sum_out), .scratch_out(scratch_out), .sign_out(sign_out)
  );

  function automatic logic [N:0] exp_add(logic [N-1:0] a, logic [N:0] b);
    logic [N:0] s;
    s = {1'b0, a} + {1'b0, b[N-1:0]};
    return {s[N] ^ b[N], s[N-1:0]};
  endfunction

  function automatic logic [N:0] exp_sub(logic [N-1:0] a, logic [N:0] b);
    logic [N:0] d;
    d = {1'b0, b[N-1:0]} - {1'b0, a};
    return {b[N] ^ d[N], d[N-1:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [N-1:0] a, input logic [N:0] b, input bit m,
                     input bit disturb, output logic [N:0] res);
    logic [N:0] e;
    bit early;
    string tag;
    early = 1'b0;
    e = m ? exp_sub(a, b) : exp_add(a, b);
    tag = m ? (b[N] ? "R5 sub" : "R3 sub") : (b[N] ? "R5 add" : "R2 add");
    if (disturb) tag = {tag, " R8"};
    @(negedge clk);
    a_in = a; b_in = b; sub_mode = m; start = 1'b1;
    @(negedge clk);
    start = disturb;
    if (disturb) begin a_in = ~a; b_in = ~b; sub_mode = ~m; end
    chk(busy == 1'b1, "R7 busy after capture", int'(busy), 1);
    for (int c = 1; c < T; c++) begin
      if (c == T - 1) start = 1'b0;
      @(negedge clk);
      if (done) early = 1'b1;
    end
    @(negedge clk);
    chk(!early && done && !busy, "R7 done timing", int'(early), 0);
    chk(sum_out == e, tag, int'(sum_out), int'(e));
    chk(scratch_out == '0, "R6 scratch zero", int'(scratch_out), 0);
    chk(a_out == a, "R9 a preserved", int'(a_out), int'(a));
    chk(sign_out == e[N], "R4 sign flag", int'(sign_out), int'(e[N]));
    if (m && !b[N])
      chk(sign_out == (b[N-1:0] < a), "R4 compare", int'(sign_out), int'(b[N-1:0] < a));
    res = sum_out;
    @(negedge clk);
    chk(done == 1'b0, "R7 done pulse", int'(done), 0);
    a_in = '0; b_in = '0; sub_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      nvec++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [N:0] r, r2;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 idle flags", int'(busy) + int'(done), 0);
    chk(a_out == '0 && sum_out == '0 && scratch_out == '0, "R1 registers",
        int'(sum_out), 0);
    rst_n = 1'b1;

    run('0, '0, 1'b0, 1'b0, r);
    run({N{1'b1}}, {1'b0, {N{1'b1}}}, 1'b0, 1'b0, r);
    run({N{1'b1}}, '0, 1'b1, 1'b0, r);
    run('0, '0, 1'b1, 1'b0, r);

    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << (N + 1)); b++)
        for (int m = 0; m < 2; m++)
          run(N'(a), (N+1)'(b), m[0], 1'b0, r);

    for (int t = 0; t < 150; t++) begin
      logic [N-1:0] ra;
      logic [N:0]   rb;
      ra = N'($urandom);
      rb = (N+1)'($urandom);
      run(ra, rb, 1'b0, t[0], r);
      run(ra, r, 1'b1, ~t[0], r2);
      chk(r2 == rb, "R5 round trip", int'(r2), int'(rb));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule